// File: doc/BRIEF.md
# Armed Gated Frequency Counter

This block measures the frequency of a digital input by counting its rising edges inside a window set by a periodic timebase reference. The reference (nominally one pulse every 10 ms) enters on channel A and the signal under test on channel B. Both inputs are already synchronized to the system clock. A rising edge of the reference arms the block and opens the gate. The next rising edge closes it. While the gate is open, every rising edge of B increments a saturating counter. When the gate closes, the total is latched onto `count_o` and `done_o` pulses for one clock.

The gate is the AND of two registers: an arm flag and a gate flag. Both are set by an opening reference edge and both are cleared by the closing one, so each new measurement needs a fresh reference edge to arm it. Two arm lines can block the channels. Driving `arm_a_i` low stops B edges from reaching the counter. Driving `arm_b_i` high stops reference edges from reaching the gate logic.

Top module: `armed_freq_counter`

## Requirements
- R1: After reset is asserted, `count_o` reads 0, `done_o` is low and the gate is closed.
- R2: A reference rising edge that is not blocked, arriving while the gate is closed, opens the gate from the next clock onward.
- R3: Rising edges of `b_i` are counted only while the gate is open. Edges while the gate is closed leave the result and the next window's count unchanged.
- R4: A reference rising edge that is not blocked, arriving while the gate is open, closes the gate. `count_o` then shows the number of B edges seen in the window, and `done_o` is high for exactly one clock.
- R5: A B edge in the same clock as the closing reference edge is not counted.
- R6: While `arm_a_i` is 0, B edges are ignored. While it is 1, they pass.
- R7: While `arm_b_i` is 1, reference edges are ignored and can neither open nor close the gate.
- R8: The window count saturates at 2^CNT_W-1 and does not wrap.
- R9: Closing clears the arm flag and the counter. `count_o` holds its value until the next close, and every window starts from zero.
- R10: Only 0-to-1 transitions count, so a B level held high for many clocks counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Channel A: timebase reference pulses |
| b_i | input | 1 | Channel B: signal being measured |
| arm_a_i | input | 1 | Low blocks channel B |
| arm_b_i | input | 1 | High blocks channel A |
| count_o | output | CNT_W | Latched count of the last window |
| done_o | output | 1 | One-clock pulse when a window closes |

## Verification
The hardest situation to reach is a reference edge blocked while the gate is already open. From the ports, the gate can only be seen through the next result. The bench opens a window, raises `arm_b_i` around a reference pulse, and then checks two things: `done_o` stays low, and the later unblocked close reports the B edges from both sides of the blocked pulse. A second hard case is a B edge in the same clock as the closing reference edge. The bench drives both inputs in one cycle and expects that edge to be dropped. Saturation uses a narrow counter width so that enough edges fit in a short run.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_SIG = 1;
  localparam int unsigned N_CH   = 2;
endpackage

// File: rtl/afc_edge_det.sv
module afc_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/afc_gate_ctrl.sv
module afc_gate_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_evt_i,
  output logic gate_open_o,
  output logic close_o
);
  logic arm_q, gate_q;

  assign gate_open_o = arm_q & gate_q;
  assign close_o     = ref_evt_i & gate_open_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (ref_evt_i) begin
      if (gate_open_o) begin
        // close the window and disarm: the next window needs a fresh arming edge
        arm_q  <= 1'b0;
        gate_q <= 1'b0;
      end else begin
        arm_q  <= 1'b1;
        gate_q <= 1'b1;
      end
    end
  end

  a_r2_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_evt_i && !gate_open_o) |=> gate_open_o);
  a_r4_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_evt_i && gate_open_o) |=> !gate_open_o);
endmodule

// File: rtl/afc_counter.sv
module afc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_open_i,
  input  logic             close_i,
  input  logic             sig_evt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= close_i;
      if (close_i) begin
        count_o <= cnt_q;
        cnt_q   <= '0;
      end else if (gate_open_i && sig_evt_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !close_i) |=> cnt_q == CNT_MAX);
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_open_i |-> cnt_q == '0);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_i |=> $stable(count_o));
endmodule

// File: rtl/armed_freq_counter.sv
module armed_freq_counter
  import afc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             b_i,
  input  logic             arm_a_i,
  input  logic             arm_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic [N_CH-1:0] lvl, rise;
  logic            ref_evt, sig_evt, gate_open, close;

  assign lvl[CH_REF] = ref_i;
  assign lvl[CH_SIG] = b_i;

  afc_edge_det #(.N(N_CH)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  // cross-inhibit: the arm line of one channel blocks the other
  assign ref_evt = rise[CH_REF] & ~arm_b_i;
  assign sig_evt = rise[CH_SIG] & arm_a_i;

  afc_gate_ctrl u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_evt_i  (ref_evt),
    .gate_open_o(gate_open),
    .close_o    (close)
  );

  afc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_open_i(gate_open),
    .close_i    (close),
    .sig_evt_i  (sig_evt),
    .count_o    (count_o),
    .done_o     (done_o)
  );

  a_r7_ref_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[CH_REF] && arm_b_i) |=> $stable(gate_open));
  a_r4_done_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |=> done_o);
endmodule

// File: tb/armed_freq_counter_test.sv
`timescale 1ns/1ps
module armed_freq_counter_test;
  localparam int unsigned W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_s = 1'b0, b = 1'b0, arm_a = 1'b1, arm_b = 1'b0;
  logic [W-1:0] count;
  logic done;
  int runs = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  armed_freq_counter #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .b_i(b),
    .arm_a_i(arm_a), .arm_b_i(arm_b), .count_o(count), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic b_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      b = 1'b1; @(negedge clk);
      b = 1'b0; @(negedge clk);
    end
  endtask

  task automatic ref_pulse();
    ref_s = 1'b1; @(negedge clk);
    ref_s = 1'b0; @(negedge clk);
  endtask

  // closing pulse: done high in the clock after the edge, then low
  task automatic close_check(input string req, input int exp);
    ref_s = 1'b1; @(negedge clk);
    check(req, done, 1);
    check(req, count, exp);
    ref_s = 1'b0; @(negedge clk);
    check("R4 single", done, 0);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_basic();
    ref_pulse();
    b_pulses(5);
    close_check("R2 R3 R4 basic", 5);
  endtask

  task automatic t_outside();
    b_pulses(4);
    check("R9 hold", count, 5);
    check("R3 closed no done", done, 0);
    ref_pulse();
    b_pulses(3);
    close_check("R3 R9 fresh window", 3);
  endtask

  task automatic t_coincident();
    ref_pulse();
    b_pulses(2);
    b = 1'b1;
    close_check("R5 coincident", 2);
    b = 1'b0; @(negedge clk);
  endtask

  task automatic t_arm_a();
    ref_pulse();
    arm_a = 1'b0;
    b_pulses(4);
    arm_a = 1'b1;
    b_pulses(1);
    close_check("R6 arm_a", 1);
  endtask

  task automatic t_arm_b();
    arm_b = 1'b1;
    ref_pulse();
    check("R7 no open", done, 0);
    arm_b = 1'b0;
    b_pulses(3);
    ref_pulse();
    b_pulses(2);
    close_check("R7 blocked open", 2);
    ref_pulse();
    b_pulses(1);
    arm_b = 1'b1;
    ref_s = 1'b1; @(negedge clk);
    check("R7 no close", done, 0);
    ref_s = 1'b0; @(negedge clk);
    arm_b = 1'b0;
    b_pulses(1);
    close_check("R7 blocked close", 2);
  endtask

  task automatic t_level();
    ref_pulse();
    b = 1'b1;
    repeat (10) @(negedge clk);
    b = 1'b0; @(negedge clk);
    close_check("R10 level", 1);
  endtask

  task automatic t_sat();
    ref_pulse();
    b_pulses(300);
    close_check("R8 saturate", 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_outside();
    t_coincident();
    t_arm_a();
    t_arm_b();
    t_level();
    t_sat();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!finished) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule